// File: doc/BRIEF.md
# Machine Check Status and Request Unit

This unit collects hardware error events for a simple in-order core, records each one as a sticky status bit, and asks the core to take a machine check. It has two classes of input. Load-path errors are error reports tied to one instruction. Each carries a guarded attribute and an origin code: data cache, L2, or system interconnect. Such a report is held in a one-entry pending slot until the faulting instruction completes in program order. It is dropped if that instruction is flushed first. Asynchronous errors come in on a separate vector. They set their sticky bits at once, but they raise a request only when the machine-check enable or the guest-state input is high.

Software reads the status vector and clears bits by writing ones. A hardware set in the same cycle as a software clear of that bit wins. The request output is a one-cycle pulse. It is suppressed while the handler-busy input is high, and a suppressed request is not replayed. A completed error report raises the request whatever the mask inputs are.

Top module: `mchk_status`

## Requirements
- R1: A load error that completes (cpl_strobe while a report is pending or arriving, no flush) sets status bit 0. On the same clock edge it raises mchk_req, whatever the values of me_en and gs_mode.
- R2: Status bit 1 is set together with bit 0 only when the load was guarded and its origin code is 1 (L2) or 2 (system interconnect). A load is guarded when ld_err_guard_attr is 1 or force_guard is 1.
- R3: A guarded load whose origin code is 0 (data cache) sets bit 0 only. Bit 1 stays 0.
- R4: Before cpl_strobe arrives, a load error changes no status bit and raises no request.
- R5: A flush discards the pending or incoming report. A later cpl_strobe then sets no bit and raises no request.
- R6: async_err[i] sets status bit 2+i on the next edge, whatever the masks are.
- R7: An asynchronous error raises mchk_req only when me_en or gs_mode is 1.
- R8: Writing with sw_wr_en clears each status bit whose sw_wr_data bit is 1. A data bit of 0 leaves its status bit unchanged.
- R9: When a hardware set and a software clear hit the same bit in one cycle, the bit ends up set.
- R10: mchk_req is never high for two cycles in a row. It is low in the cycle after handler_busy was sampled high. A blocked request is dropped.
- R11: While a report is pending, further ld_err_valid events are ignored. The first report is the one committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_err_valid | input | 1 | Load error event for an in-flight instruction |
| ld_err_guard_attr | input | 1 | Page attribute of the load marks it guarded |
| ld_err_origin | input | 2 | Error origin: 0 data cache, 1 L2, 2 interconnect |
| force_guard | input | 1 | Global control that treats every load as guarded |
| cpl_strobe | input | 1 | Faulting instruction is ready to complete |
| flush | input | 1 | Faulting instruction is flushed |
| async_err | input | NUM_ASYNC | Asynchronous error events |
| me_en | input | 1 | Machine-check enable mask |
| gs_mode | input | 1 | Guest-state mask |
| handler_busy | input | 1 | Handler active; blocks a new request |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 2+NUM_ASYNC | Write-one-to-clear data |
| status | output | 2+NUM_ASYNC | Sticky status: bit 0 load error, bit 1 guarded report, 2+i asynchronous |
| mchk_req | output | 1 | Machine-check request pulse |

## Verification
On every cycle the assertions check these properties:
- The request pulse is one cycle wide and is blocked by handler_busy.
- A masked asynchronous error never requests.
- Asynchronous errors always reach their sticky bits.
- No status bit falls without a software write.
- The guarded-report bit never rises without the load-error bit.

Some behaviour only the bench scenarios can show. This covers the origin-dependent choice of bit 1, deferral until completion, discarding on flush, first-report retention, and set beating clear. The bench shows these by comparing against its reference model and with directed checks of the expected status words.

// File: rtl/mchk_pkg.sv
package mchk_pkg;

    typedef enum logic [1:0] {
        ORG_DCACHE = 2'd0,
        ORG_L2     = 2'd1,
        ORG_FABRIC = 2'd2,
        ORG_RSVD   = 2'd3
    } err_origin_e;

    localparam int unsigned BIT_LOAD   = 0;
    localparam int unsigned BIT_GUARD  = 1;
    localparam int unsigned ASYNC_BASE = 2;

    typedef struct packed {
        logic        guarded;
        err_origin_e origin;
    } load_evt_t;

    function automatic logic guard_report(load_evt_t e);
        return e.guarded && (e.origin == ORG_L2 || e.origin == ORG_FABRIC);
    endfunction

endpackage

// File: rtl/mchk_report_track.sv
module mchk_report_track
    import mchk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      evt_valid,
    input  load_evt_t evt,
    input  logic      cpl_strobe,
    input  logic      flush,
    output logic      commit,
    output logic      commit_guard
);
    logic      pend_v;
    load_evt_t pend_q;
    load_evt_t eff;
    logic      eff_v;

    assign eff          = pend_v ? pend_q : evt;
    assign eff_v        = pend_v | evt_valid;
    assign commit       = cpl_strobe & eff_v & ~flush;
    assign commit_guard = guard_report(eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_q <= '0;
        end else if (flush || commit) begin
            pend_v <= 1'b0;
        end else if (evt_valid && !pend_v) begin
            pend_v <= 1'b1;
            pend_q <= evt;
        end
    end
endmodule

// File: rtl/mchk_async_gate.sv
module mchk_async_gate #(
    parameter int unsigned NUM_ASYNC = 4
) (
    input  logic [NUM_ASYNC-1:0] async_err,
    input  logic                 me_en,
    input  logic                 gs_mode,
    output logic [NUM_ASYNC-1:0] async_set,
    output logic                 async_trig
);
    logic enabled;
    assign enabled = me_en | gs_mode;

    for (genvar i = 0; i < NUM_ASYNC; i++) begin : g_src
        assign async_set[i] = async_err[i];
    end

    assign async_trig = (|async_err) & enabled;
endmodule

// File: rtl/mchk_req_gen.sv
module mchk_req_gen (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic busy,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= trig & ~busy & ~req;
    end
endmodule

// File: rtl/mchk_status.sv
module mchk_status
    import mchk_pkg::*;
#(
    parameter int unsigned NUM_ASYNC = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ld_err_valid,
    input  logic                            ld_err_guard_attr,
    input  logic [1:0]                      ld_err_origin,
    input  logic                            force_guard,
    input  logic                            cpl_strobe,
    input  logic                            flush,
    input  logic [NUM_ASYNC-1:0]            async_err,
    input  logic                            me_en,
    input  logic                            gs_mode,
    input  logic                            handler_busy,
    input  logic                            sw_wr_en,
    input  logic [ASYNC_BASE+NUM_ASYNC-1:0] sw_wr_data,
    output logic [ASYNC_BASE+NUM_ASYNC-1:0] status,
    output logic                            mchk_req
);
    localparam int unsigned SW = ASYNC_BASE + NUM_ASYNC;

    load_evt_t            evt;
    logic                 commit, commit_guard;
    logic [NUM_ASYNC-1:0] async_set;
    logic                 async_trig;
    logic [SW-1:0]        set_vec, clr_vec;

    assign evt.guarded = ld_err_guard_attr | force_guard;
    assign evt.origin  = err_origin_e'(ld_err_origin);

    mchk_report_track u_track (
        .clk          (clk),
        .rst          (rst),
        .evt_valid    (ld_err_valid),
        .evt          (evt),
        .cpl_strobe   (cpl_strobe),
        .flush        (flush),
        .commit       (commit),
        .commit_guard (commit_guard)
    );

    mchk_async_gate #(.NUM_ASYNC(NUM_ASYNC)) u_gate (
        .async_err  (async_err),
        .me_en      (me_en),
        .gs_mode    (gs_mode),
        .async_set  (async_set),
        .async_trig (async_trig)
    );

    mchk_req_gen u_req (
        .clk  (clk),
        .rst  (rst),
        .trig (commit | async_trig),
        .busy (handler_busy),
        .req  (mchk_req)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[BIT_LOAD]  = commit;
        set_vec[BIT_GUARD] = commit & commit_guard;
        set_vec[SW-1:ASYNC_BASE] = async_set;
        clr_vec = sw_wr_en ? sw_wr_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/mchk_status_chk.sv
module mchk_status_chk #(
    parameter int unsigned NUM_ASYNC = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cpl_strobe,
    input logic [NUM_ASYNC-1:0]   async_err,
    input logic                   me_en,
    input logic                   gs_mode,
    input logic                   handler_busy,
    input logic                   sw_wr_en,
    input logic [NUM_ASYNC+1:0]   status,
    input logic                   mchk_req
);
    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        mchk_req |=> !mchk_req);

    p_busy_block_r10: assert property (@(posedge clk) disable iff (rst)
        handler_busy |=> !mchk_req);

    p_masked_async_r7: assert property (@(posedge clk) disable iff (rst)
        ((|async_err) && !me_en && !gs_mode && !cpl_strobe) |=> !mchk_req);

    p_async_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (|async_err) |=> ((status[NUM_ASYNC+1:2] & $past(async_err)) == $past(async_err)));

    p_no_fall_r8: assert property (@(posedge clk) disable iff (rst)
        !sw_wr_en |=> (($past(status) & ~status) == '0));

    p_guard_with_load_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |-> status[0]);
endmodule

bind mchk_status mchk_status_chk #(.NUM_ASYNC(NUM_ASYNC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpl_strobe   (cpl_strobe),
    .async_err    (async_err),
    .me_en        (me_en),
    .gs_mode      (gs_mode),
    .handler_busy (handler_busy),
    .sw_wr_en     (sw_wr_en),
    .status       (status),
    .mchk_req     (mchk_req)
);

// File: tb/mchk_status_bench.sv
module mchk_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 4;
    localparam int SW = NA + 2;

    logic clk = 0, rst = 1;
    logic ld_v = 0, attr = 0, fg = 0, cpl = 0, fl = 0;
    logic [1:0] org = 0;
    logic [NA-1:0] aerr = 0;
    logic me = 0, gs = 0, busy = 0, wr = 0;
    logic [SW-1:0] wd = 0;
    logic [SW-1:0] status;
    logic mchk_req;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mchk_status #(.NUM_ASYNC(NA)) u_mchk_status (
        .clk(clk), .rst(rst), .ld_err_valid(ld_v), .ld_err_guard_attr(attr),
        .ld_err_origin(org), .force_guard(fg), .cpl_strobe(cpl), .flush(fl),
        .async_err(aerr), .me_en(me), .gs_mode(gs), .handler_busy(busy),
        .sw_wr_en(wr), .sw_wr_data(wd), .status(status), .mchk_req(mchk_req)
    );

    // behavioural reference model
    bit m_pend = 0, m_pg = 0, m_req = 0;
    logic [SW-1:0] m_st = '0;
    always @(posedge clk) begin
        bit g_in, eff_v, eff_g, fire;
        logic [SW-1:0] setv;
        g_in  = (attr || fg) && (org == 2'd1 || org == 2'd2);
        if (rst) begin
            m_pend = 0; m_pg = 0; m_req = 0; m_st = '0;
        end else begin
            eff_v = m_pend || ld_v;
            eff_g = m_pend ? m_pg : g_in;
            fire  = 0;
            setv  = {aerr, 2'b00};
            if (fl) m_pend = 0;
            else if (cpl && eff_v) begin
                fire = 1; m_pend = 0;
                setv[0] = 1; setv[1] = eff_g;
            end else if (ld_v && !m_pend) begin
                m_pend = 1; m_pg = g_in;
            end
            m_st  = (m_st & ~(wr ? wd : '0)) | setv;
            m_req = (fire || ((|aerr) && (me || gs))) && !busy && !m_req;
        end
    end

    always @(negedge clk) if (!rst && !done) begin
        checks++;
        if (status !== m_st || mchk_req !== m_req) begin
            fails++;
            $display("FAIL model R1/R6: status=%b req=%b expected status=%b req=%b",
                     status, mchk_req, m_st, m_req);
        end
    end

    task automatic chk(string req, logic [SW:0] act, logic [SW:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle();
        ld_v = 0; attr = 0; fg = 0; cpl = 0; fl = 0; org = 0;
        aerr = 0; busy = 0; wr = 0; wd = 0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk); idle();
    endtask

    task automatic wipe();
        wr = 1; wd = '1; step(); step();
    endtask

    task automatic load_cpl(logic a, logic f, logic [1:0] o);
        ld_v = 1; attr = a; fg = f; org = o; step();
        cpl = 1; step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1; fails++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 reset", {mchk_req, status}, '0);

        // R4 deferral then R1/R2 commit
        ld_v = 1; attr = 1; org = 2'd1; step();
        chk("R4", {mchk_req, status}, '0);
        cpl = 1; step();
        chk("R1 R2 guarded L2", {mchk_req, status}, {1'b1, 6'b000011});
        step();
        chk("R10 pulse", {6'b0, mchk_req}, 7'd0);
        wr = 1; wd = 6'b000011; step();
        chk("R8 clear", {1'b0, status}, '0);

        load_cpl(0, 0, 2'd1);
        chk("R2 unguarded", {mchk_req, status}, {1'b1, 6'b000001});
        wipe();

        me = 0; gs = 0;
        load_cpl(0, 1, 2'd2);
        chk("R1 R2 forced interconnect masked", {mchk_req, status}, {1'b1, 6'b000011});
        wipe();

        load_cpl(1, 0, 2'd0);
        chk("R3 dcache", {mchk_req, status}, {1'b1, 6'b000001});
        wipe();

        ld_v = 1; attr = 1; org = 2'd1; step();
        fl = 1; step();
        cpl = 1; step();
        chk("R5 flush", {mchk_req, status}, '0);

        aerr = 4'b0001; step();
        chk("R6 R7 masked async", {mchk_req, status}, {1'b0, 6'b000100});
        gs = 1; aerr = 4'b0010; step();
        chk("R7 guest async", {mchk_req, status}, {1'b1, 6'b001100});
        gs = 0;
        wr = 1; wd = 6'b0; step();
        chk("R8 zero write", {1'b0, status}, {1'b0, 6'b001100});
        wr = 1; wd = 6'b000100; step();
        chk("R8 single clear", {1'b0, status}, {1'b0, 6'b001000});
        wr = 1; wd = 6'b001000; aerr = 4'b0001; aerr[1] = 1; step();
        chk("R9 set wins", {1'b0, status}, {1'b0, 6'b001100});
        wipe();

        me = 1; busy = 1; aerr = 4'b0100; step();
        chk("R10 busy", {mchk_req, status}, {1'b0, 6'b010000});
        wipe();
        aerr = 4'b1000; step();
        chk("R10 first", {6'b0, mchk_req}, 7'd1);
        aerr = 4'b1000; step();
        chk("R10 second", {6'b0, mchk_req}, 7'd0);
        me = 0; wipe();

        ld_v = 1; attr = 1; org = 2'd0; step();
        ld_v = 1; attr = 1; org = 2'd1; step();
        cpl = 1; step();
        chk("R11 first kept", {mchk_req, status}, {1'b1, 6'b000001});
        step();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule